// File: doc/BRIEF.md
# Buffered Flash Word Program Sequencer

This block sits in the write path of a NOR flash array. Software first opens an operation with a start address and a word count. It then streams the data words into a small local buffer and confirms. On confirm the block checks the whole target run. The run must be non-empty, no longer than the buffer, held inside one block, clear of the one-time-programmable region and aimed at an unlocked block. If the run passes, the block writes the buffered words to the array on consecutive addresses, one word per clock cycle. If any check fails, the array is left untouched and a sticky error flag is raised.

Commands arrive on a valid/ready handshake with a 2-bit opcode. While the write-out runs, the command port is closed. Lock state is obtained by presenting the block index of the run on a query port, and the answer comes back in the same cycle. Block size, buffer depth, address and data widths, and the protected region are all parameters.

Top module: `pgb_prog_ctrl`

## Requirements
- R1: After reset, busy, done, err and arr_we are 0 and cmd_ready is 1.
- R2: A START command (cmd_op = 1) whose cmd_count is 0 or greater than DEPTH (16) sets err, opens no operation, and leads to no array write.
- R3: After a successful confirm, word i of the buffer (in load order) is written to address start+i, on consecutive cycles, with exactly cmd_count writes.
- R4: No array write happens before CONFIRM (cmd_op = 2). A CONFIRM issued while fewer words than cmd_count have been loaded sets err and writes nothing.
- R5: A run whose first and last addresses lie in different blocks (block index = address / BLK_WORDS, 1024 by default) is rejected with err set and no writes. A run that ends exactly on the last word of a block is accepted.
- R6: A run that overlaps the protected region [OTP_BASE, OTP_BASE+OTP_WORDS), which is addresses 0 to 7 by default, is rejected with err set and no writes. A run that starts just past the region is accepted.
- R7: lock_blk shows the block index of the open run. If lock_locked is 1 at confirm, the run is rejected with err set and no writes.
- R8: busy rises in the cycle after an accepted confirm, stays high for exactly cmd_count cycles together with arr_we, and done pulses for one cycle right after busy falls.
- R9: err stays set until CLEAR (cmd_op = 3) is accepted. A later successful operation does not clear it.
- R10: While busy, cmd_ready is 0 and any command, CLEAR included, is ignored.
- R11: Words pushed after cmd_count words have been loaded are ignored.
- R12: A word pushed in the same cycle as CONFIRM counts toward the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command valid |
| cmd_op | input | 2 | 0 none, 1 START, 2 CONFIRM, 3 CLEAR |
| cmd_addr | input | ADDR_W | Start address (START) |
| cmd_count | input | CNT_W | Word count (START) |
| cmd_ready | output | 1 | Command accepted when high |
| wr_valid | input | 1 | Data word strobe into buffer |
| wr_data | input | DATA_W | Data word |
| lock_blk | output | ADDR_W-log2(BLK_WORDS) | Block index of the open run |
| lock_locked | input | 1 | Lock answer for lock_blk |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_data | output | DATA_W | Array write data |
| busy | output | 1 | Write-out in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky program error |

## Verification
The final data word and the confirm can arrive in the same clock cycle. In that case the fill count that confirm compares against must already include the word being written. The bench provokes this by raising wr_valid with the fourth word of a four-word run in the same cycle as CONFIRM. It judges the result by seeing four array writes carrying the right data and err still clear. A design that compared against the stale fill count would instead reject the run as short.

// File: rtl/pgb_pkg.sv
package pgb_pkg;

   typedef enum logic [1:0] {
      OP_NONE    = 2'd0,
      OP_START   = 2'd1,
      OP_CONFIRM = 2'd2,
      OP_CLEAR   = 2'd3
   } pgb_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOAD = 2'd1,
      ST_PROG = 2'd2
   } pgb_state_e;

endpackage

// File: rtl/pgb_buf.sv
module pgb_buf #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 16
) (
   input  logic                       clk,
   input  logic                       wr_en,
   input  logic [$clog2(DEPTH)-1:0]   wr_idx,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic [$clog2(DEPTH)-1:0]   rd_idx,
   output logic [DATA_W-1:0]          rd_data
);
   localparam int IDX_W = $clog2(DEPTH);

   logic [DATA_W-1:0] ent [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
         if (wr_en && (wr_idx == IDX_W'(i))) q <= wr_data;
      end
      assign ent[i] = q;
   end

   assign rd_data = ent[rd_idx];

endmodule

// File: rtl/pgb_range_chk.sv
module pgb_range_chk #(
   parameter int          ADDR_W    = 16,
   parameter int          CNT_W     = 6,
   parameter int          DEPTH     = 16,
   parameter int          BLK_WORDS = 1024,
   parameter int unsigned OTP_BASE  = 0,
   parameter int unsigned OTP_WORDS = 8
) (
   input  logic [ADDR_W-1:0]                     first,
   input  logic [CNT_W-1:0]                      run_count,
   input  logic [CNT_W-1:0]                      new_count,
   output logic                                  count_bad,
   output logic                                  crosses,
   output logic                                  hits_otp,
   output logic [ADDR_W-$clog2(BLK_WORDS)-1:0]   blk_idx
);
   localparam int BLK_SH = $clog2(BLK_WORDS);

   logic [ADDR_W:0] last;

   assign last      = {1'b0, first} + (ADDR_W+1)'(run_count) - (ADDR_W+1)'(1);
   assign crosses   = last[ADDR_W] || (last[ADDR_W-1:BLK_SH] != first[ADDR_W-1:BLK_SH]);
   assign count_bad = (new_count == '0) || (new_count > CNT_W'(DEPTH));
   assign blk_idx   = first[ADDR_W-1:BLK_SH];

   if (OTP_WORDS == 0) begin : g_no_otp
      assign hits_otp = 1'b0;
   end else begin : g_otp
      logic [ADDR_W+1:0] otp_end;
      logic [ADDR_W+1:0] d_last;
      assign otp_end  = (ADDR_W+2)'(OTP_BASE) + (ADDR_W+2)'(OTP_WORDS);
      assign d_last   = {1'b0, last} - (ADDR_W+2)'(OTP_BASE);
      assign hits_otp = ({2'b00, first} < otp_end) && !d_last[ADDR_W+1];
   end

endmodule

// File: rtl/pgb_seq.sv
module pgb_seq
   import pgb_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 6,
   parameter int DEPTH  = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cmd_valid,
   input  logic [1:0]                   cmd_op,
   input  logic [ADDR_W-1:0]            cmd_addr,
   input  logic [CNT_W-1:0]             cmd_count,
   output logic                         cmd_ready,
   input  logic                         wr_valid,
   input  logic                         count_bad,
   input  logic                         crosses,
   input  logic                         hits_otp,
   input  logic                         locked,
   output logic [ADDR_W-1:0]            start_q,
   output logic [CNT_W-1:0]             count_q,
   output logic                         buf_we,
   output logic [$clog2(DEPTH)-1:0]     buf_widx,
   output logic [$clog2(DEPTH)-1:0]     buf_ridx,
   output logic                         arr_we,
   output logic [ADDR_W-1:0]            arr_addr,
   output logic                         busy,
   output logic                         done,
   output logic                         err
);
   localparam int IDX_W  = $clog2(DEPTH);
   localparam int FILL_W = $clog2(DEPTH + 1);

   pgb_state_e        state;
   logic [FILL_W-1:0] fill_q;
   logic [FILL_W-1:0] fill_nx;
   logic [IDX_W-1:0]  idx_q;
   logic              err_q;
   logic              done_q;
   logic              acc;
   logic              is_start;
   logic              take;
   logic              reject;
   logic              last_beat;

   assign cmd_ready = (state != ST_PROG);
   assign acc       = cmd_valid && cmd_ready;
   assign is_start  = acc && (pgb_op_e'(cmd_op) == OP_START);
   assign take      = (state == ST_LOAD) && wr_valid && !is_start
                      && (CNT_W'(fill_q) < count_q);
   assign fill_nx   = fill_q + FILL_W'(take);
   assign reject    = (CNT_W'(fill_nx) != count_q) || crosses || hits_otp || locked;
   assign last_beat = (CNT_W'(idx_q) == (count_q - CNT_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         start_q <= '0;
         count_q <= '0;
         fill_q  <= '0;
         idx_q   <= '0;
         err_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (state == ST_PROG) begin
            idx_q <= idx_q + IDX_W'(1);
            if (last_beat) begin
               state  <= ST_IDLE;
               done_q <= 1'b1;
            end
         end else begin
            if (take) fill_q <= fill_nx;
            if (acc) begin
               unique case (pgb_op_e'(cmd_op))
                  OP_START: begin
                     if (count_bad) begin
                        err_q <= 1'b1;
                        state <= ST_IDLE;
                     end else begin
                        start_q <= cmd_addr;
                        count_q <= cmd_count;
                        fill_q  <= '0;
                        state   <= ST_LOAD;
                     end
                  end
                  OP_CONFIRM: begin
                     if (state == ST_LOAD) begin
                        if (reject) begin
                           err_q <= 1'b1;
                           state <= ST_IDLE;
                        end else begin
                           idx_q <= '0;
                           state <= ST_PROG;
                        end
                     end
                  end
                  OP_CLEAR: err_q <= 1'b0;
                  default: ;
               endcase
            end
         end
      end
   end

   assign buf_we   = take;
   assign buf_widx = fill_q[IDX_W-1:0];
   assign buf_ridx = idx_q;
   assign arr_we   = (state == ST_PROG);
   assign busy     = (state == ST_PROG);
   assign arr_addr = start_q + ADDR_W'(idx_q);
   assign done     = done_q;
   assign err      = err_q;

endmodule

// File: rtl/pgb_prog_ctrl.sv
module pgb_prog_ctrl #(
   parameter int          ADDR_W    = 16,
   parameter int          DATA_W    = 16,
   parameter int          DEPTH     = 16,
   parameter int          CNT_W     = 6,
   parameter int          BLK_WORDS = 1024,
   parameter int unsigned OTP_BASE  = 0,
   parameter int unsigned OTP_WORDS = 8
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 cmd_valid,
   input  logic [1:0]                           cmd_op,
   input  logic [ADDR_W-1:0]                    cmd_addr,
   input  logic [CNT_W-1:0]                     cmd_count,
   output logic                                 cmd_ready,
   input  logic                                 wr_valid,
   input  logic [DATA_W-1:0]                    wr_data,
   output logic [ADDR_W-$clog2(BLK_WORDS)-1:0]  lock_blk,
   input  logic                                 lock_locked,
   output logic                                 arr_we,
   output logic [ADDR_W-1:0]                    arr_addr,
   output logic [DATA_W-1:0]                    arr_data,
   output logic                                 busy,
   output logic                                 done,
   output logic                                 err
);
   localparam int IDX_W = $clog2(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("pgb_prog_ctrl: DEPTH must be at least 2");
   end
   if ((BLK_WORDS & (BLK_WORDS - 1)) != 0 || BLK_WORDS < DEPTH) begin : g_bad_blk
      $error("pgb_prog_ctrl: BLK_WORDS must be a power of two not below DEPTH");
   end
   if (CNT_W < $clog2(DEPTH + 1)) begin : g_bad_cnt
      $error("pgb_prog_ctrl: CNT_W too narrow for DEPTH");
   end
   if ($clog2(BLK_WORDS) >= ADDR_W) begin : g_bad_addr
      $error("pgb_prog_ctrl: ADDR_W must exceed log2(BLK_WORDS)");
   end

   logic [ADDR_W-1:0] start_q;
   logic [CNT_W-1:0]  count_q;
   logic              count_bad;
   logic              crosses;
   logic              hits_otp;
   logic              buf_we;
   logic [IDX_W-1:0]  buf_widx;
   logic [IDX_W-1:0]  buf_ridx;

   pgb_range_chk #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEPTH(DEPTH), .BLK_WORDS(BLK_WORDS),
      .OTP_BASE(OTP_BASE), .OTP_WORDS(OTP_WORDS)
   ) u_chk_rng (
      .first(start_q), .run_count(count_q), .new_count(cmd_count),
      .count_bad(count_bad), .crosses(crosses), .hits_otp(hits_otp),
      .blk_idx(lock_blk)
   );

   pgb_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
      .cmd_count(cmd_count), .cmd_ready(cmd_ready), .wr_valid(wr_valid),
      .count_bad(count_bad), .crosses(crosses), .hits_otp(hits_otp),
      .locked(lock_locked), .start_q(start_q), .count_q(count_q),
      .buf_we(buf_we), .buf_widx(buf_widx), .buf_ridx(buf_ridx),
      .arr_we(arr_we), .arr_addr(arr_addr), .busy(busy), .done(done), .err(err)
   );

   pgb_buf #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_buf (
      .clk(clk), .wr_en(buf_we), .wr_idx(buf_widx), .wr_data(wr_data),
      .rd_idx(buf_ridx), .rd_data(arr_data)
   );

endmodule

// File: rtl/pgb_prog_ctrl_chk.sv
module pgb_prog_ctrl_chk #(
   parameter int          ADDR_W    = 16,
   parameter int          BLK_WORDS = 1024,
   parameter int unsigned OTP_BASE  = 0,
   parameter int unsigned OTP_WORDS = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [1:0]        cmd_op,
   input logic              cmd_ready,
   input logic              lock_locked,
   input logic              arr_we,
   input logic [ADDR_W-1:0] arr_addr,
   input logic              busy,
   input logic              done,
   input logic              err
);
   localparam int BLK_SH = $clog2(BLK_WORDS);

   logic [ADDR_W:0] otp_ofs;
   logic            in_otp;
   assign otp_ofs = {1'b0, arr_addr} - (ADDR_W+1)'(OTP_BASE);
   assign in_otp  = (OTP_WORDS != 0) && (otp_ofs < (ADDR_W+1)'(OTP_WORDS));

   assert_busy_after_confirm_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cmd_valid && cmd_op == 2'd2));

   assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   assert_seq_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_we && $past(arr_we)) |-> (arr_addr == ADDR_W'($past(arr_addr) + 1'b1)));

   assert_one_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_we && $past(arr_we)) |-> (arr_addr[ADDR_W-1:BLK_SH] == $past(arr_addr[ADDR_W-1:BLK_SH])));

   assert_no_otp_R6: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> !in_otp);

   assert_not_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> !lock_locked);

   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !(cmd_valid && cmd_ready && cmd_op == 2'd3)) |=> err);

endmodule

bind pgb_prog_ctrl pgb_prog_ctrl_chk #(
   .ADDR_W(ADDR_W), .BLK_WORDS(BLK_WORDS), .OTP_BASE(OTP_BASE), .OTP_WORDS(OTP_WORDS)
) u_prop_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
   .cmd_ready(cmd_ready), .lock_locked(lock_locked), .arr_we(arr_we),
   .arr_addr(arr_addr), .busy(busy), .done(done), .err(err)
);

// File: tb/pgb_prog_ctrl_tb.sv
`timescale 1ns/1ps
module pgb_prog_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_op = 2'd0;
   logic [15:0] cmd_addr = '0;
   logic [5:0]  cmd_count = '0;
   logic        cmd_ready;
   logic        wr_valid = 1'b0;
   logic [15:0] wr_data = '0;
   logic [5:0]  lock_blk;
   logic        lock_locked;
   logic        arr_we;
   logic [15:0] arr_addr;
   logic [15:0] arr_data;
   logic        busy;
   logic        done;
   logic        err;

   logic [63:0] lock_mask = '0;
   assign lock_locked = lock_mask[lock_blk];

   int tests = 0;
   int fails = 0;
   int wcnt  = 0;
   logic [15:0] wa [64];
   logic [15:0] wd [64];

   always #2 clk = ~clk;

   pgb_prog_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_count(cmd_count), .cmd_ready(cmd_ready),
      .wr_valid(wr_valid), .wr_data(wr_data), .lock_blk(lock_blk),
      .lock_locked(lock_locked), .arr_we(arr_we), .arr_addr(arr_addr),
      .arr_data(arr_data), .busy(busy), .done(done), .err(err)
   );

   always @(negedge clk) begin
      if (arr_we) begin
         if (wcnt < 64) begin
            wa[wcnt] = arr_addr;
            wd[wcnt] = arr_data;
         end
         wcnt = wcnt + 1;
      end
   end

   task automatic check(input logic ok, input string tag, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_cmd(input logic [1:0] op, input logic [15:0] a, input logic [5:0] c);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_count = c;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 2'd0;
   endtask

   task automatic push_words(input int n, input logic [15:0] base);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         wr_valid = 1'b1; wr_data = base + 16'(i);
      end
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic wait_idle(output int n, output logic d);
      n = 0;
      while (busy && n < 100) begin
         n++;
         @(negedge clk);
      end
      d = done;
   endtask

   task automatic check_writes(input string tag, input logic [15:0] a, input int n, input logic [15:0] base);
      check(wcnt == n, {tag, " write count"}, wcnt, n);
      for (int i = 0; i < n && i < 64; i++) begin
         check(wa[i] == a + 16'(i), {tag, " address"}, wa[i], a + 16'(i));
         check(wd[i] == base + 16'(i), {tag, " data"}, wd[i], base + 16'(i));
      end
   endtask

   task automatic clear_err();
      do_cmd(2'd3, '0, '0);
      check(err == 1'b0, "R9 clear", err, 0);
   endtask

   task automatic t_reset();
      check(busy == 0 && done == 0 && arr_we == 0, "R1 reset outputs", {busy, done, arr_we}, 0);
      check(err == 0, "R1 reset err", err, 0);
      check(cmd_ready == 1, "R1 reset ready", cmd_ready, 1);
   endtask

   task automatic t_basic();
      int n; logic d;
      wcnt = 0;
      do_cmd(2'd1, 16'h0100, 6'd4);
      push_words(4, 16'hA000);
      check(wcnt == 0, "R4 no write before confirm", wcnt, 0);
      do_cmd(2'd2, '0, '0);
      check(busy == 1, "R8 busy after confirm", busy, 1);
      wait_idle(n, d);
      check(n == 4, "R8 busy length", n, 4);
      check(d == 1, "R8 done pulse", d, 1);
      @(negedge clk);
      check(done == 0, "R8 done single cycle", done, 0);
      check_writes("R3 basic", 16'h0100, 4, 16'hA000);
      check(err == 0, "R3 no error", err, 0);
   endtask

   task automatic t_block_edge();
      int n; logic d;
      wcnt = 0;
      do_cmd(2'd1, 16'h03F0, 6'd16);
      push_words(16, 16'hB000);
      do_cmd(2'd2, '0, '0);
      wait_idle(n, d);
      check(n == 16, "R8 full busy length", n, 16);
      check_writes("R5 run ending on block edge", 16'h03F0, 16, 16'hB000);
      check(err == 0, "R5 edge accepted", err, 0);
   endtask

   task automatic t_cross();
      wcnt = 0;
      do_cmd(2'd1, 16'h03F8, 6'd16);
      push_words(16, 16'hC000);
      do_cmd(2'd2, '0, '0);
      check(err == 1, "R5 cross rejected", err, 1);
      check(busy == 0, "R5 cross not busy", busy, 0);
      repeat (20) @(negedge clk);
      check(wcnt == 0, "R5 cross no writes", wcnt, 0);
      clear_err();
   endtask

   task automatic t_otp();
      int n; logic d;
      wcnt = 0;
      do_cmd(2'd1, 16'h0004, 6'd4);
      push_words(4, 16'hD000);
      do_cmd(2'd2, '0, '0);
      check(err == 1, "R6 protected overlap rejected", err, 1);
      repeat (6) @(negedge clk);
      check(wcnt == 0, "R6 protected no writes", wcnt, 0);
      clear_err();
      do_cmd(2'd1, 16'h0008, 6'd2);
      push_words(2, 16'hD100);
      do_cmd(2'd2, '0, '0);
      wait_idle(n, d);
      check_writes("R6 just past region", 16'h0008, 2, 16'hD100);
      check(err == 0, "R6 past region accepted", err, 0);
   endtask

   task automatic t_locked();
      wcnt = 0;
      lock_mask[5] = 1'b1;
      do_cmd(2'd1, 16'h1400, 6'd2);
      check(lock_blk == 6'd5, "R7 lock query index", lock_blk, 5);
      push_words(2, 16'hE000);
      do_cmd(2'd2, '0, '0);
      check(err == 1, "R7 locked rejected", err, 1);
      repeat (4) @(negedge clk);
      check(wcnt == 0, "R7 locked no writes", wcnt, 0);
      lock_mask[5] = 1'b0;
      clear_err();
   endtask

   task automatic t_count_bad();
      wcnt = 0;
      do_cmd(2'd1, 16'h0200, 6'd0);
      check(err == 1, "R2 zero count error", err, 1);
      push_words(2, 16'h1111);
      do_cmd(2'd2, '0, '0);
      repeat (4) @(negedge clk);
      check(wcnt == 0, "R2 zero count no writes", wcnt, 0);
      clear_err();
      do_cmd(2'd1, 16'h0200, 6'd17);
      check(err == 1, "R2 oversize count error", err, 1);
      do_cmd(2'd2, '0, '0);
      repeat (20) @(negedge clk);
      check(wcnt == 0, "R2 oversize no writes", wcnt, 0);
      clear_err();
   endtask

   task automatic t_short();
      wcnt = 0;
      do_cmd(2'd1, 16'h0300, 6'd4);
      push_words(3, 16'h2200);
      do_cmd(2'd2, '0, '0);
      check(err == 1, "R4 short load rejected", err, 1);
      repeat (6) @(negedge clk);
      check(wcnt == 0, "R4 short load no writes", wcnt, 0);
      clear_err();
   endtask

   task automatic t_sticky_and_busy();
      int n; logic d;
      do_cmd(2'd1, 16'h0400, 6'd0);
      check(err == 1, "R9 error set", err, 1);
      wcnt = 0;
      do_cmd(2'd1, 16'h0400, 6'd8);
      push_words(8, 16'h3300);
      do_cmd(2'd2, '0, '0);
      check(cmd_ready == 0, "R10 not ready while busy", cmd_ready, 0);
      cmd_valid = 1'b1; cmd_op = 2'd3;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 2'd0;
      wait_idle(n, d);
      check_writes("R9 write with error set", 16'h0400, 8, 16'h3300);
      check(err == 1, "R10 clear ignored while busy", err, 1);
      check(err == 1, "R9 success keeps error", err, 1);
      clear_err();
   endtask

   task automatic t_extra();
      int n; logic d;
      wcnt = 0;
      do_cmd(2'd1, 16'h0500, 6'd3);
      push_words(5, 16'h4400);
      do_cmd(2'd2, '0, '0);
      wait_idle(n, d);
      check_writes("R11 extra words", 16'h0500, 3, 16'h4400);
      check(err == 0, "R11 no error", err, 0);
   endtask

   task automatic t_same_cycle();
      int n; logic d;
      wcnt = 0;
      do_cmd(2'd1, 16'h0600, 6'd4);
      push_words(3, 16'h5500);
      @(negedge clk);
      wr_valid = 1'b1; wr_data = 16'h5503;
      cmd_valid = 1'b1; cmd_op = 2'd2;
      @(negedge clk);
      wr_valid = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0;
      check(err == 0, "R12 same-cycle confirm accepted", err, 0);
      wait_idle(n, d);
      check_writes("R12 same-cycle word", 16'h0600, 4, 16'h5500);
   endtask

   initial begin
      #(4 * 150000);
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_block_edge();
      t_cross();
      t_otp();
      t_locked();
      t_count_bad();
      t_short();
      t_sticky_and_busy();
      t_extra();
      t_same_cycle();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule